// File: doc/BRIEF.md
# Deferred Fault Register Tag Tracker

This block keeps one poison bit for each architectural register so that loads can be hoisted speculatively without trapping. A speculative load that would have faulted writes back with its fault flag raised. The block suppresses the trap and marks the destination register as poisoned. The fault then travels with the value. It becomes a real exception only when a non-speculative instruction consumes that register as an operand. A speculative instruction that reads a poisoned register does not trap. It hands the poison on to its own destination.

A check request names a register and carries a recovery address. If the register is poisoned, the block raises a one-cycle redirect carrying that address. If the register is clean, the check has no effect. Fault detection and the recovery code lie outside the block.

All requests are sampled in one cycle and their results appear on registered outputs in the next cycle. Every read in a cycle sees the poison bits as they stood at the start of that cycle. The reset input is asserted asynchronously and is released through a two-stage synchronizer. Requests are therefore honoured from the third rising edge after the reset input goes high.

Top module: `poison_tracker`

## Requirements
- R1: Reset clears every poison bit. It also holds the exception and redirect outputs low.
- R2: A speculative load writeback never produces an exception. If its fault flag is high, it sets the poison bit of its destination register.
- R3: A speculative load writeback with its fault flag low clears the poison bit of its destination.
- R4: A non-speculative load writeback, or a non-speculative instruction that completes and writes a destination, clears that destination's poison bit.
- R5: Consider a non-speculative instruction that reads a poisoned register through a valid operand port. One cycle later, exc_valid is high. exc_tag gives the register and exc_port gives the operand port index (port 0 is the first).
- R6: When several valid operand ports of one non-speculative instruction read poisoned registers, exactly one exception is reported. It names the lowest-numbered of those ports.
- R7: A speculative instruction never raises an exception. If it writes a destination, that destination's poison bit becomes the OR of the poison bits of its valid operands.
- R8: A check on a poisoned register makes redir_valid high for exactly one cycle, in the cycle after the request. redir_addr carries the recovery address given with the request.
- R9: A check on a clean register, or a cycle with no check, leaves redir_valid low.
- R10: Operand reads and checks see the poison bits from before the current cycle's writes. When a load writeback and an instruction write the same register in one cycle, the load's value is kept.
- R11: A non-speculative instruction that raises an exception leaves its destination's poison bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| ld_valid | input | 1 | Load writeback valid |
| ld_spec | input | 1 | Load was speculative |
| ld_fault | input | 1 | Load would have faulted |
| ld_tag | input | TAG_W | Load destination register |
| ex_valid | input | 1 | Instruction operand read valid |
| ex_spec | input | 1 | Instruction is speculative |
| ex_src_valid | input | NUM_SRC | Per-port operand valid |
| ex_src_tag | input | NUM_SRC*TAG_W | Operand registers, port p at bits p*TAG_W upward |
| ex_dst_valid | input | 1 | Instruction writes a destination |
| ex_dst_tag | input | TAG_W | Instruction destination register |
| chk_valid | input | 1 | Check request valid |
| chk_tag | input | TAG_W | Register being checked |
| chk_target | input | ADDR_W | Recovery address for the check |
| exc_valid | output | 1 | Deferred fault exception, one cycle |
| exc_port | output | PORT_W | Operand port that raised it |
| exc_tag | output | TAG_W | Poisoned register consumed |
| redir_valid | output | 1 | Redirect to recovery, one cycle |
| redir_addr | output | ADDR_W | Recovery address |

## Verification
Several properties are checked on every cycle. Speculative loads and speculative instructions never trap. A faulting speculative load sets its destination bit and a clean or non-speculative load clears it. A check hits or misses according to the stored bit. Port 0 wins any trap it is part of. Other behaviours depend on sequences of operations and only the bench's scenarios can show them. These are the propagation of poison through chains of speculative instructions, and the lowest-port choice when port 0 is clean. They also include the load-over-instruction write priority, a trapping instruction leaving its destination untouched, and reads seeing old state in a cycle that also writes.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;
  // Index width for n items, never below one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pt_flag_file.sv
`timescale 1ns/1ps
module pt_flag_file #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned TAG_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid,
  input  logic                ld_value,
  input  logic [TAG_W-1:0]    ld_tag,
  input  logic                ex_wr,
  input  logic                ex_value,
  input  logic [TAG_W-1:0]    ex_tag,
  output logic [NUM_REGS-1:0] flags
);
  logic [NUM_REGS-1:0] flag_q, flag_d, flag_en;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit_ld, hit_ex;
    always_comb begin
      hit_ld     = ld_valid && (ld_tag == TAG_W'(i));
      hit_ex     = ex_wr && (ex_tag == TAG_W'(i));
      flag_en[i] = hit_ld || hit_ex;
      // Load writeback has priority over the instruction result.
      flag_d[i]  = hit_ld ? ld_value : ex_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/pt_operand_screen.sv
`timescale 1ns/1ps
module pt_operand_screen #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned PORT_W   = 1
) (
  input  logic [NUM_REGS-1:0]      flags,
  input  logic                     ex_valid,
  input  logic                     ex_spec,
  input  logic [NUM_SRC-1:0]       src_valid,
  input  logic [NUM_SRC*TAG_W-1:0] src_tag,
  output logic                     any_poison,
  output logic                     trap,
  output logic [PORT_W-1:0]        trap_port,
  output logic [TAG_W-1:0]         trap_tag
);
  logic [NUM_SRC-1:0] hit;

  for (genvar p = 0; p < NUM_SRC; p++) begin : g_port
    assign hit[p] = src_valid[p] && flags[src_tag[p*TAG_W +: TAG_W]];
  end

  always_comb begin
    trap_port = '0;
    trap_tag  = '0;
    // Scan downward so the lowest poisoned port is the one kept.
    for (int p = NUM_SRC - 1; p >= 0; p--) begin
      if (hit[p]) begin
        trap_port = PORT_W'(p);
        trap_tag  = src_tag[p*TAG_W +: TAG_W];
      end
    end
    any_poison = |hit;
    trap       = ex_valid && !ex_spec && any_poison;
  end
endmodule

// File: rtl/pt_check_unit.sv
`timescale 1ns/1ps
module pt_check_unit #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned ADDR_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] flags,
  input  logic                chk_valid,
  input  logic [TAG_W-1:0]    chk_tag,
  input  logic [ADDR_W-1:0]   chk_target,
  output logic                redir_valid,
  output logic [ADDR_W-1:0]   redir_addr
);
  logic redir_d;

  always_comb redir_d = chk_valid && flags[chk_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redir_valid <= 1'b0;
    else        redir_valid <= redir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       redir_addr <= '0;
    else if (redir_d) redir_addr <= chk_target;
  end
endmodule

// File: rtl/poison_tracker.sv
`timescale 1ns/1ps
module poison_tracker #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned ADDR_W   = 32,
  localparam int unsigned TAG_W   = pt_pkg::idx_w(NUM_REGS),
  localparam int unsigned PORT_W  = pt_pkg::idx_w(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_valid,
  input  logic                     ld_spec,
  input  logic                     ld_fault,
  input  logic [TAG_W-1:0]         ld_tag,
  input  logic                     ex_valid,
  input  logic                     ex_spec,
  input  logic [NUM_SRC-1:0]       ex_src_valid,
  input  logic [NUM_SRC*TAG_W-1:0] ex_src_tag,
  input  logic                     ex_dst_valid,
  input  logic [TAG_W-1:0]         ex_dst_tag,
  input  logic                     chk_valid,
  input  logic [TAG_W-1:0]         chk_tag,
  input  logic [ADDR_W-1:0]        chk_target,
  output logic                     exc_valid,
  output logic [PORT_W-1:0]        exc_port,
  output logic [TAG_W-1:0]         exc_tag,
  output logic                     redir_valid,
  output logic [ADDR_W-1:0]        redir_addr
);
  // Reset synchronizer: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [NUM_REGS-1:0] flags;
  logic                any_poison, trap;
  logic [PORT_W-1:0]   trap_port;
  logic [TAG_W-1:0]    trap_tag;
  logic                ld_value, ex_wr, ex_value;

  always_comb begin
    ld_value = ld_spec && ld_fault;
    ex_wr    = ex_valid && ex_dst_valid && !trap;
    ex_value = ex_spec && any_poison;
  end

  pt_operand_screen #(
    .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .TAG_W(TAG_W), .PORT_W(PORT_W)
  ) u_screen (
    .flags(flags), .ex_valid(ex_valid), .ex_spec(ex_spec),
    .src_valid(ex_src_valid), .src_tag(ex_src_tag),
    .any_poison(any_poison), .trap(trap),
    .trap_port(trap_port), .trap_tag(trap_tag)
  );

  pt_flag_file #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_flags (
    .clk(clk), .rst_n(rst_i_n),
    .ld_valid(ld_valid), .ld_value(ld_value), .ld_tag(ld_tag),
    .ex_wr(ex_wr), .ex_value(ex_value), .ex_tag(ex_dst_tag),
    .flags(flags)
  );

  pt_check_unit #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_check (
    .clk(clk), .rst_n(rst_i_n), .flags(flags),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_target(chk_target),
    .redir_valid(redir_valid), .redir_addr(redir_addr)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) exc_valid <= 1'b0;
    else          exc_valid <= trap;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      exc_port <= '0;
      exc_tag  <= '0;
    end else if (trap) begin
      exc_port <= trap_port;
      exc_tag  <= trap_tag;
    end
  end
endmodule

// File: rtl/pt_checker.sv
`timescale 1ns/1ps
module pt_checker #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned PORT_W   = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_REGS-1:0]      flags,
  input logic                     ld_valid,
  input logic                     ld_spec,
  input logic                     ld_fault,
  input logic [TAG_W-1:0]         ld_tag,
  input logic                     ex_valid,
  input logic                     ex_spec,
  input logic [NUM_SRC-1:0]       ex_src_valid,
  input logic [NUM_SRC*TAG_W-1:0] ex_src_tag,
  input logic                     chk_valid,
  input logic [TAG_W-1:0]         chk_tag,
  input logic [ADDR_W-1:0]        chk_target,
  input logic                     exc_valid,
  input logic [PORT_W-1:0]        exc_port,
  input logic [TAG_W-1:0]         exc_tag,
  input logic                     redir_valid,
  input logic [ADDR_W-1:0]        redir_addr
);
  p_spec_load_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_spec && !(ex_valid && !ex_spec) |=> !exc_valid);

  p_fault_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_spec && ld_fault |=> flags[$past(ld_tag)]);

  p_clean_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !(ld_spec && ld_fault) |=> !flags[$past(ld_tag)]);

  p_port0_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_spec && ex_src_valid[0] && flags[ex_src_tag[TAG_W-1:0]]
    |=> exc_valid && (exc_port == '0) && (exc_tag == $past(ex_src_tag[TAG_W-1:0])));

  p_spec_no_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && ex_spec |=> !exc_valid);

  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && flags[chk_tag] |=> redir_valid && (redir_addr == $past(chk_target)));

  p_no_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_valid && flags[chk_tag]) |=> !redir_valid);
endmodule

bind poison_tracker pt_checker #(
  .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
  .TAG_W(TAG_W), .PORT_W(PORT_W)
) u_pt_checker (
  .clk(clk), .rst_n(rst_i_n), .flags(flags),
  .ld_valid(ld_valid), .ld_spec(ld_spec), .ld_fault(ld_fault), .ld_tag(ld_tag),
  .ex_valid(ex_valid), .ex_spec(ex_spec), .ex_src_valid(ex_src_valid),
  .ex_src_tag(ex_src_tag),
  .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_target(chk_target),
  .exc_valid(exc_valid), .exc_port(exc_port), .exc_tag(exc_tag),
  .redir_valid(redir_valid), .redir_addr(redir_addr)
);

// File: tb/test_poison_tracker.sv
`timescale 1ns/1ps
module test_poison_tracker;
  localparam int NR = 16;
  localparam int NS = 2;
  localparam int TW = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid, ld_spec, ld_fault;
  logic [TW-1:0] ld_tag;
  logic ex_valid, ex_spec, ex_dst_valid;
  logic [NS-1:0] ex_src_valid;
  logic [NS*TW-1:0] ex_src_tag;
  logic [TW-1:0] ex_dst_tag;
  logic chk_valid;
  logic [TW-1:0] chk_tag;
  logic [AW-1:0] chk_target;
  logic exc_valid, redir_valid;
  logic [0:0] exc_port;
  logic [TW-1:0] exc_tag;
  logic [AW-1:0] redir_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit mf [NR];

  always #4 clk = ~clk;

  poison_tracker i_poison_tracker (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_spec(ld_spec), .ld_fault(ld_fault), .ld_tag(ld_tag),
    .ex_valid(ex_valid), .ex_spec(ex_spec), .ex_src_valid(ex_src_valid),
    .ex_src_tag(ex_src_tag), .ex_dst_valid(ex_dst_valid), .ex_dst_tag(ex_dst_tag),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_target(chk_target),
    .exc_valid(exc_valid), .exc_port(exc_port), .exc_tag(exc_tag),
    .redir_valid(redir_valid), .redir_addr(redir_addr)
  );

  task automatic idle();
    ld_valid = 0; ld_spec = 0; ld_fault = 0; ld_tag = '0;
    ex_valid = 0; ex_spec = 0; ex_src_valid = '0; ex_src_tag = '0;
    ex_dst_valid = 0; ex_dst_tag = '0;
    chk_valid = 0; chk_tag = '0; chk_target = '0;
  endtask

  // One cycle: expected results come from the requirement model mf.
  task automatic cyc(input string req);
    bit et, er, or_s;
    int ep, etg;
    et = 0; or_s = 0; ep = 0; etg = 0;
    for (int p = NS - 1; p >= 0; p--)
      if (ex_src_valid[p] && mf[ex_src_tag[p*TW +: TW]]) begin
        or_s = 1; ep = p; etg = int'(ex_src_tag[p*TW +: TW]);
      end
    et = ex_valid && !ex_spec && or_s;
    er = chk_valid && mf[chk_tag];
    @(posedge clk); @(negedge clk);
    n_cmp++;
    if (exc_valid !== et || (et && (int'(exc_port) != ep || int'(exc_tag) != etg))) begin
      n_bad++;
      $display("FAIL %s exc: got v=%0b port=%0d tag=%0d, expected v=%0b port=%0d tag=%0d",
               req, exc_valid, exc_port, exc_tag, et, ep, etg);
    end
    n_cmp++;
    if (redir_valid !== er || (er && redir_addr !== chk_target)) begin
      n_bad++;
      $display("FAIL %s redir: got v=%0b addr=%h, expected v=%0b addr=%h",
               req, redir_valid, redir_addr, er, chk_target);
    end
    if (ex_valid && ex_dst_valid && !et) mf[ex_dst_tag] = ex_spec ? or_s : 1'b0;
    if (ld_valid) mf[ld_tag] = ld_spec && ld_fault;
    idle();
  endtask

  task automatic probe(input int r, input string req);
    chk_valid = 1; chk_tag = TW'(r); chk_target = 32'hA000_0000 + r * 16;
    cyc(req);
  endtask

  task automatic sload(input int r, input bit f, input string req);
    ld_valid = 1; ld_spec = 1; ld_fault = f; ld_tag = TW'(r);
    cyc(req);
  endtask

  task automatic use2(input bit spec, input bit v0, input int a, input bit v1,
                      input int b, input bit dv, input int d, input string req);
    ex_valid = 1; ex_spec = spec; ex_src_valid = {v1, v0};
    ex_src_tag = {TW'(b), TW'(a)}; ex_dst_valid = dv; ex_dst_tag = TW'(d);
    cyc(req);
  endtask

  initial begin
    #(200000 * 8);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    for (int i = 0; i < NR; i++) mf[i] = 0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (exc_valid !== 1'b0 || redir_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 outputs in reset: exc=%0b redir=%0b expected 0 0", exc_valid, redir_valid);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: every register clean after reset
    for (int r = 0; r < NR; r++) begin
      probe(r, "R1");
      use2(0, 1, r, 0, 0, 0, 0, "R1");
    end
    // R2/R5/R8: poison each register, check it, then consume it on port 1
    for (int r = 0; r < NR; r++) begin
      sload(r, 1, "R2");
      probe(r, "R8");
      cyc("R8");
      use2(0, 0, 0, 1, r, 0, 0, "R5");
      // R3/R9: clean speculative load clears it
      sload(r, 0, "R3");
      probe(r, "R9");
    end
    // R4: non-speculative writes clear
    for (int r = 0; r < NR; r++) begin
      sload(r, 1, "R4");
      use2(0, 0, 0, 0, 0, 1, r, "R4");
      probe(r, "R4");
      sload(r, 1, "R4");
      ld_valid = 1; ld_spec = 0; ld_fault = 1; ld_tag = TW'(r); cyc("R4");
      probe(r, "R4");
    end
    // R6: pairs of operands, all combinations of poison
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        sload(a, 1, "R6");
        sload(b, (a + b) % 2 == 1, "R6");
        use2(0, 1, a, 1, b, 0, 0, "R6");
        use2(0, 1, b, 1, a, 0, 0, "R6");
        sload(a, 0, "R6");
        use2(0, 1, a, 1, b, 0, 0, "R6");
        sload(b, 0, "R6");
      end
    // R7: speculative propagation chain
    for (int r = 0; r < NR - 2; r++) begin
      sload(r, 1, "R7");
      use2(1, 1, r, 1, r + 1, 1, r + 2, "R7");
      probe(r + 2, "R7");
      use2(1, 1, r + 1, 0, r, 1, r + 2, "R7");
      probe(r + 2, "R7");
      sload(r, 0, "R7");
    end
    // R10: reads see old state; load wins over instruction write
    for (int r = 0; r < NR; r++) begin
      ld_valid = 1; ld_spec = 1; ld_fault = 1; ld_tag = TW'(r);
      ex_valid = 1; ex_src_valid = 2'b01; ex_src_tag = {TW'(0), TW'(r)};
      chk_valid = 1; chk_tag = TW'(r); chk_target = 32'h5000 + r;
      cyc("R10");
      probe(r, "R10");
      sload((r + 1) % NR, 1, "R10");
      ld_valid = 1; ld_spec = 1; ld_fault = 0; ld_tag = TW'(r);
      ex_valid = 1; ex_spec = 1; ex_src_valid = 2'b01;
      ex_src_tag = {TW'(0), TW'((r + 1) % NR)}; ex_dst_valid = 1; ex_dst_tag = TW'(r);
      cyc("R10");
      probe(r, "R10");
      sload((r + 1) % NR, 0, "R10");
    end
    // R11: trapping instruction leaves its destination as it was
    for (int r = 0; r < NR - 1; r++) begin
      sload(r, 1, "R11");
      sload(r + 1, 1, "R11");
      use2(0, 1, r, 0, 0, 1, r + 1, "R11");
      probe(r + 1, "R11");
      sload(r + 1, 0, "R11");
      use2(0, 1, r, 0, 0, 1, r + 1, "R11");
      probe(r + 1, "R11");
      sload(r, 0, "R11");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule